// File: doc/BRIEF.md
# Half-Duplex Collision Detector

This block guards a half-duplex serial link whose receiver listens to the same wire the transmitter drives. Examples are a smart-card style single-wire line, or a two-wire RS485 bus with the transceiver's driver and receiver both switched on. While a frame is going out, the block compares the bit being driven against the bit the receiver samples at mid-bit. A difference means another station is also driving the line.

On a collision the block starts a fixed recovery. In the cycle after the offending sample it raises, for one cycle each, an abort pulse for the framing logic, a flush pulse for the transmit buffer and FIFO, a collision flag and a transmit-complete pulse. It then holds a busy flag for a parameterised synchronisation delay. When the delay ends it clears its own transmitter enable, which releases the TX pin to high impedance.

The pin stays released until software asks for the transmitter again. The framing state machine and the buffer storage sit outside this block and react to its pulses.

Top module: `hd_coll_det`

## Requirements
- R1: With `det_en` low no collision is ever detected, and `coll_o`, `abort_o`, `flush_o`, `txc_o` and `busy_o` stay low.
- R2: A collision is detected at a rising clock edge only when all of the following hold at that edge: `det_en`, `frame_act`, `smp_stb` and `tx_oe` are high, and `tx_bit` differs from `rx_bit` (1 against 0, or 0 against 1). No other input combination starts the recovery.
- R3: `abort_o` and `flush_o` are high for exactly the one cycle that follows the detecting edge.
- R4: `coll_o` and `txc_o` are high together for exactly the one cycle that follows the detecting edge.
- R5: `busy_o` rises in the cycle after the detecting edge and stays high for exactly `SYNC_DLY` clock cycles.
- R6: `tx_oe` stays high while `busy_o` is high and goes low in the same cycle that `busy_o` falls. It then stays low, with the pin tri-stated, until a request is honoured.
- R7: A one-cycle `txen_req` pulse sets `tx_oe` high at the next edge when `busy_o` is low. A request sampled while `busy_o` is high is ignored.
- R8: While `busy_o` is high, further mismatches at the sample strobe start no new recovery and produce no pulses.
- R9: After reset every output is low, and the transmitter is disabled until it is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| det_en | input | 1 | Collision detection enable |
| frame_act | input | 1 | High while a frame is being transmitted |
| tx_bit | input | 1 | Bit currently driven on the TX line |
| rx_bit | input | 1 | Looped-back received bit |
| smp_stb | input | 1 | Mid-bit sample strobe |
| txen_req | input | 1 | Software request to enable the transmitter |
| abort_o | output | 1 | One-cycle abort of the frame in progress |
| flush_o | output | 1 | One-cycle flush of transmit buffer and FIFO |
| coll_o | output | 1 | One-cycle collision flag |
| txc_o | output | 1 | One-cycle transmit-complete pulse |
| busy_o | output | 1 | Disable synchronisation in progress |
| tx_oe | output | 1 | TX pin output enable (low means tri-stated) |

## Verification
The bench builds the block with `SYNC_DLY` = 3. This keeps the whole recovery window short enough to walk cycle by cycle, while still leaving interior busy cycles in which to inject stray requests and extra mismatches. It sweeps all 64 combinations of detect enable, frame activity, strobe, TX bit, RX bit and transmitter state. For every combination that should collide, it follows the pulses, the busy window, the pin release, an ignored request and a later honoured one.

// File: rtl/hdcd_pkg.sv
// Package: shared types for the half-duplex collision detector.
// Assumes: nothing beyond a single clock domain.
package hdcd_pkg;

    // One-cycle recovery event outputs, grouped for routing.
    typedef struct packed {
        logic abort;
        logic flush;
        logic coll;
        logic txc;
    } hdcd_evt_t;

endpackage

// File: rtl/hdcd_cmp.sv
// Module: hdcd_cmp
// Compares the driven bit with the looped-back sampled bit and qualifies
// the mismatch with every enabling condition.
// Assumes: rx_bit is already synchronised and smp_stb marks mid-bit.
module hdcd_cmp (
    input  logic det_en,
    input  logic frame_act,
    input  logic tx_on,
    input  logic busy,
    input  logic smp_stb,
    input  logic tx_bit,
    input  logic rx_bit,
    output logic hit
);

    logic mismatch;

    // Purpose: raw bit difference and its qualification.
    always_comb begin
        mismatch = tx_bit ^ rx_bit;
        hit      = det_en & frame_act & tx_on & smp_stb & mismatch & ~busy;
    end

endmodule

// File: rtl/hdcd_recov.sv
// Module: hdcd_recov
// Issues the one-cycle recovery pulses after a detected collision and times
// the synchronisation delay that precedes the transmitter shut-down.
// Assumes: SYNC_DLY >= 1; hit is never raised while busy is high.
module hdcd_recov
    import hdcd_pkg::*;
#(
    parameter int SYNC_DLY = 3
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hit,
    output hdcd_evt_t evt,
    output logic      busy,
    output logic      done
);

    // Purpose: register the recovery pulses one cycle after the hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt <= '0;
        end else begin
            evt.abort <= hit;
            evt.flush <= hit;
            evt.coll  <= hit;
            evt.txc   <= hit;
        end
    end

    generate
        if (SYNC_DLY == 1) begin : g_nocnt
            // Purpose: single-cycle busy window, no counter needed.
            always_ff @(posedge clk) begin
                if (!rst_n)    busy <= 1'b0;
                else if (hit)  busy <= 1'b1;
                else if (busy) busy <= 1'b0;
            end
            assign done = busy;
        end else begin : g_cnt
            localparam int CW = $clog2(SYNC_DLY);
            localparam logic [CW-1:0] LOAD = CW'(SYNC_DLY - 1);
            logic [CW-1:0] cnt;

            // Purpose: count down the synchronisation delay while busy.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    busy <= 1'b0;
                    cnt  <= '0;
                end else if (hit) begin
                    busy <= 1'b1;
                    cnt  <= LOAD;
                end else if (busy) begin
                    if (cnt == '0) busy <= 1'b0;
                    else           cnt  <= cnt - 1'b1;
                end
            end
            assign done = busy && (cnt == '0);
        end
    endgenerate

endmodule

// File: rtl/hdcd_txen.sv
// Module: hdcd_txen
// Holds the transmitter enable: set by a software request when idle,
// cleared by hardware when the disable delay completes.
// Assumes: done is a single-cycle strobe coincident with the last busy cycle.
module hdcd_txen (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic busy,
    input  logic done,
    output logic tx_on
);

    // Purpose: enable register, hardware clear dominating software set.
    always_ff @(posedge clk) begin
        if (!rst_n)            tx_on <= 1'b0;
        else if (done)         tx_on <= 1'b0;
        else if (req && !busy) tx_on <= 1'b1;
    end

endmodule

// File: rtl/hd_coll_det.sv
// Module: hd_coll_det (top)
// Half-duplex collision detector: compares driven and looped-back bits,
// runs the abort/flush/complete recovery and auto-disables the TX pin.
// Assumes: synchronous active-low reset, all inputs in the clk domain.
module hd_coll_det
    import hdcd_pkg::*;
#(
    parameter int SYNC_DLY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic det_en,
    input  logic frame_act,
    input  logic tx_bit,
    input  logic rx_bit,
    input  logic smp_stb,
    input  logic txen_req,
    output logic abort_o,
    output logic flush_o,
    output logic coll_o,
    output logic txc_o,
    output logic busy_o,
    output logic tx_oe
);

    logic      hit;
    logic      busy;
    logic      done;
    logic      tx_on;
    hdcd_evt_t evt;

    hdcd_cmp u_cmp (
        .det_en    (det_en),
        .frame_act (frame_act),
        .tx_on     (tx_on),
        .busy      (busy),
        .smp_stb   (smp_stb),
        .tx_bit    (tx_bit),
        .rx_bit    (rx_bit),
        .hit       (hit)
    );

    hdcd_recov #(.SYNC_DLY(SYNC_DLY)) u_recov (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit),
        .evt   (evt),
        .busy  (busy),
        .done  (done)
    );

    hdcd_txen u_txen (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (txen_req),
        .busy  (busy),
        .done  (done),
        .tx_on (tx_on)
    );

    // Purpose: drive the output ports from internal state.
    always_comb begin
        abort_o = evt.abort;
        flush_o = evt.flush;
        coll_o  = evt.coll;
        txc_o   = evt.txc;
        busy_o  = busy;
        tx_oe   = tx_on;
    end

endmodule

// File: rtl/hd_coll_det_chk.sv
// Module: hd_coll_det_chk
// Assertion checker for hd_coll_det, attached by bind.
// Assumes: same clock and reset as the checked instance.
module hd_coll_det_chk (
    input logic clk,
    input logic rst_n,
    input logic det_en,
    input logic frame_act,
    input logic tx_bit,
    input logic rx_bit,
    input logic smp_stb,
    input logic abort_o,
    input logic flush_o,
    input logic coll_o,
    input logic txc_o,
    input logic busy_o,
    input logic tx_oe
);

    AST_COLL_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        coll_o |-> $past(det_en));                                   // R1
    AST_COLL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        coll_o |-> $past(frame_act && smp_stb && tx_oe && (tx_bit != rx_bit))); // R2
    AST_ABORT_FLUSH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_o || flush_o) |=> !(abort_o || flush_o));             // R3
    AST_TXC_WITH_COLL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (coll_o && txc_o));                        // R4
    AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
        coll_o |-> busy_o);                                          // R5
    AST_OE_DURING_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> tx_oe);                                           // R6
    AST_OE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> !tx_oe);                                   // R6
    AST_REQ_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_oe) |-> !$past(busy_o));                            // R7
    AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !coll_o) |=> !coll_o);                            // R8

endmodule

bind hd_coll_det hd_coll_det_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .det_en    (det_en),
    .frame_act (frame_act),
    .tx_bit    (tx_bit),
    .rx_bit    (rx_bit),
    .smp_stb   (smp_stb),
    .abort_o   (abort_o),
    .flush_o   (flush_o),
    .coll_o    (coll_o),
    .txc_o     (txc_o),
    .busy_o    (busy_o),
    .tx_oe     (tx_oe)
);

// File: tb/hd_coll_det_bench.sv
// Bench: sweeps every input combination of the detector and follows each
// collision through its full recovery window.
module hd_coll_det_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DLY        = 3;

    logic clk = 1'b0;
    logic rst_n, det_en, frame_act, tx_bit, rx_bit, smp_stb, txen_req;
    logic abort_o, flush_o, coll_o, txc_o, busy_o, tx_oe;
    int   n_chk = 0;
    int   n_err = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hd_coll_det #(.SYNC_DLY(DLY)) u_hd_coll_det (
        .clk(clk), .rst_n(rst_n), .det_en(det_en), .frame_act(frame_act),
        .tx_bit(tx_bit), .rx_bit(rx_bit), .smp_stb(smp_stb),
        .txen_req(txen_req), .abort_o(abort_o), .flush_o(flush_o),
        .coll_o(coll_o), .txc_o(txc_o), .busy_o(busy_o), .tx_oe(tx_oe)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle_inputs();
        det_en = 0; frame_act = 0; tx_bit = 0; rx_bit = 0;
        smp_stb = 0; txen_req = 0;
    endtask

    task automatic do_reset();
        idle_inputs();
        rst_n = 0;
        tick();
        tick();
        rst_n = 1;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: run did not end");
        summary();
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R9: reset state
        chk("R9 tx_oe", tx_oe, 1'b0);
        chk("R9 busy", busy_o, 1'b0);
        chk("R9 coll", coll_o, 1'b0);
        chk("R9 abort", abort_o, 1'b0);
        chk("R9 flush", flush_o, 1'b0);
        chk("R9 txc", txc_o, 1'b0);

        for (int i = 0; i < 64; i++) begin
            logic want_on, exp_hit;
            want_on = i[5];
            do_reset();
            if (want_on) begin
                txen_req = 1;
                tick();
                txen_req = 0;
            end
            chk("R7 setup enable", tx_oe, want_on);
            det_en = i[0]; frame_act = i[1]; smp_stb = i[2];
            tx_bit = i[3]; rx_bit = i[4];
            exp_hit = i[0] & i[1] & i[2] & want_on & (i[3] ^ i[4]);
            tick();
            idle_inputs();
            chk(i[0] ? "R2 coll" : "R1 coll", coll_o, exp_hit);
            chk("R3 abort", abort_o, exp_hit);
            chk("R3 flush", flush_o, exp_hit);
            chk("R4 txc", txc_o, exp_hit);
            chk("R5 busy start", busy_o, exp_hit);
            if (exp_hit) begin
                for (int k = 1; k < DLY; k++) begin
                    // stray request and fresh mismatch inside busy window
                    txen_req = 1;
                    det_en = 1; frame_act = 1; smp_stb = 1;
                    tx_bit = 1; rx_bit = 0;
                    tick();
                    chk("R5 busy held", busy_o, 1'b1);
                    chk("R8 no retrigger", coll_o, 1'b0);
                    chk("R3 abort single", abort_o, 1'b0);
                    chk("R6 oe in busy", tx_oe, 1'b1);
                end
                idle_inputs();
                txen_req = 1;
                tick();
                txen_req = 0;
                chk("R5 busy end", busy_o, 1'b0);
                chk("R6 oe dropped", tx_oe, 1'b0);
                tick();
                chk("R7 request ignored", tx_oe, 1'b0);
                chk("R6 stays off", busy_o, 1'b0);
                txen_req = 1;
                tick();
                txen_req = 0;
                chk("R7 re-enable", tx_oe, 1'b1);
            end else begin
                tick();
                chk("R1 no busy", busy_o, 1'b0);
                chk("R6 oe kept", tx_oe, want_on);
            end
        end
        summary();
    end

endmodule